// File: doc/BRIEF.md
# Byte Inversion and Write-Mask Codec

This block codes and decodes the data lanes of a memory data bus. It has one side-band line per byte. Each lane is 8 data wires plus that side-band wire. On the transmit side the line has two jobs. It can flag a byte that has been complemented, so that fewer wires are driven high on a bus terminated to ground. On a write it can also mark a byte as masked, meaning the byte must not be stored. The receive side undoes the complement and, for writes, recovers the mask flag.

Inversion has two enables, one for reads and one for writes. The write enable also decides how a masked byte is coded:
- With write inversion off, a high side-band line means "masked".
- With write inversion on, a masked byte is sent as all ones with the side-band line low. No real byte is sent that way, because inversion always turns a byte with five or more ones into one with at most four.

The transmit path has one optional output register stage (`OUT_REG`). The receive path is purely combinational. The block does not serialize data or handle bursts.

Top module: `dbi_codec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with all inputs low, `tx_bus_dq` and `tx_bus_dmi` are all zero.
- R2: Inversion is active for a lane when `tx_write`=1 with `inv_wr_en`=1, or `tx_write`=0 with `inv_rd_en`=1. For an unmasked byte in such a lane:
  - if the byte has five or more 1 bits, the wires carry its complement and its side-band bit is 1;
  - otherwise the wires carry the byte unchanged and the side-band bit is 0.
- R3: Whenever inversion is active and the lane is not masked, at most 4 of that lane's 8 data wires are high.
- R4: On a write with `inv_wr_en`=0 and the lane's `tx_mask` bit set, the side-band bit is 1 and the data passes unchanged.
- R5: On a write with `inv_wr_en`=1 and the lane's `tx_mask` bit set, the wires carry 8'hFF and the side-band bit is 0.
- R6: With inversion inactive and the lane not masked, the side-band bit is 0 and the data passes unchanged.
- R7: On reads (`tx_write`=0), `tx_mask` has no effect on the bus.
- R8: With `OUT_REG`=1, the transmit bus shows the coding of the inputs sampled at the previous rising clock edge.
- R9: On receive reads (`rx_write`=0), `rx_mask` is always 0. `rx_data` is the complement of the wires when `inv_rd_en`=1 and the side-band bit is 1; otherwise it is the wires unchanged.
- R10: On receive writes with `inv_wr_en`=0, `rx_mask` equals the side-band bit and `rx_data` equals the wires.
- R11: On receive writes with `inv_wr_en`=1:
  - side-band low with five or more wires high gives `rx_mask`=1 and `rx_data` equal to the wires;
  - side-band high gives the complement of the wires with `rx_mask`=0;
  - anything else passes the wires through with `rx_mask`=0.
- R12: Lane k occupies data bits [8k+7:8k] and side-band bit k, and lanes are coded independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the transmit register stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_rd_en | input | 1 | Enable inversion on reads |
| inv_wr_en | input | 1 | Enable inversion on writes (also selects the mask coding) |
| tx_write | input | 1 | Transmit byte set is write data (1) or read data (0) |
| tx_data | input | 8*LANES | Bytes to send |
| tx_mask | input | LANES | Per-lane request to mask a write byte |
| tx_bus_dq | output | 8*LANES | Coded data wires |
| tx_bus_dmi | output | LANES | Coded side-band wires, one per lane |
| rx_write | input | 1 | Received byte set is write data (1) or read data (0) |
| rx_bus_dq | input | 8*LANES | Data wires as received |
| rx_bus_dmi | input | LANES | Side-band wires as received |
| rx_data | output | 8*LANES | Decoded bytes |
| rx_mask | output | LANES | Recovered per-lane write mask |

## Verification
Several properties are checked in every cycle:
- the ceiling of four high wires for inverted-mode lanes;
- the two mask codings and the pass-through case, each checked against the inputs of the cycle before;
- the absence of a mask on receive reads;
- the plain side-band meaning when write inversion is off.

Some behaviour only the bench scenarios show:
- the exact choice between complement and pass-through at the 4-versus-5 ones boundary;
- whether the receive path treats 4 ones as data and 5 ones as a mask;
- that a read mask request is ignored;
- that the lanes do not interfere.

The bench shows these by comparing every lane against its reference model on every clock.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int LANE_W     = 8;
    localparam int CNT_W      = $clog2(LANE_W + 1);
    // a byte with this many ones or more gets complemented
    localparam int INV_THRESH = LANE_W / 2 + 1;

    function automatic logic [CNT_W-1:0] ones_of(input logic [LANE_W-1:0] b);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < LANE_W; i++) begin
            n = n + CNT_W'(b[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_pkg::*;
(
    input  logic              is_write,
    input  logic              inv_rd_en,
    input  logic              inv_wr_en,
    input  logic [LANE_W-1:0] data,
    input  logic              mask_req,
    output logic [LANE_W-1:0] dq,
    output logic              dmi
);
    logic inv_on;
    logic masked;
    logic heavy;

    always_comb begin
        inv_on = is_write ? inv_wr_en : inv_rd_en;
        masked = is_write & mask_req;
        heavy  = ones_of(data) >= CNT_W'(INV_THRESH);
        dq     = data;
        dmi    = 1'b0;
        if (masked) begin
            if (inv_wr_en) begin
                dq  = '1;
                dmi = 1'b0;
            end else begin
                dmi = 1'b1;
            end
        end else if (inv_on && heavy) begin
            dq  = ~data;
            dmi = 1'b1;
        end
    end
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
    import dbi_pkg::*;
(
    input  logic              is_write,
    input  logic              inv_rd_en,
    input  logic              inv_wr_en,
    input  logic [LANE_W-1:0] dq,
    input  logic              dmi,
    output logic [LANE_W-1:0] data,
    output logic              mask
);
    logic heavy;

    always_comb begin
        heavy = ones_of(dq) >= CNT_W'(INV_THRESH);
        data  = dq;
        mask  = 1'b0;
        if (!is_write) begin
            if (inv_rd_en && dmi) begin
                data = ~dq;
            end
        end else if (!inv_wr_en) begin
            mask = dmi;
        end else if (dmi) begin
            data = ~dq;
        end else if (heavy) begin
            mask = 1'b1;
        end
    end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int OUT_REG = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inv_rd_en,
    input  logic                    inv_wr_en,
    input  logic                    tx_write,
    input  logic [LANES*LANE_W-1:0] tx_data,
    input  logic [LANES-1:0]        tx_mask,
    output logic [LANES*LANE_W-1:0] tx_bus_dq,
    output logic [LANES-1:0]        tx_bus_dmi,
    input  logic                    rx_write,
    input  logic [LANES*LANE_W-1:0] rx_bus_dq,
    input  logic [LANES-1:0]        rx_bus_dmi,
    output logic [LANES*LANE_W-1:0] rx_data,
    output logic [LANES-1:0]        rx_mask
);
    localparam int BUS_W = LANES * LANE_W;

    logic [BUS_W-1:0] enc_dq;
    logic [LANES-1:0] enc_dmi;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dbi_lane_enc u_enc (
            .is_write (tx_write),
            .inv_rd_en(inv_rd_en),
            .inv_wr_en(inv_wr_en),
            .data     (tx_data[k*LANE_W +: LANE_W]),
            .mask_req (tx_mask[k]),
            .dq       (enc_dq[k*LANE_W +: LANE_W]),
            .dmi      (enc_dmi[k])
        );
        dbi_lane_dec u_dec (
            .is_write (rx_write),
            .inv_rd_en(inv_rd_en),
            .inv_wr_en(inv_wr_en),
            .dq       (rx_bus_dq[k*LANE_W +: LANE_W]),
            .dmi      (rx_bus_dmi[k]),
            .data     (rx_data[k*LANE_W +: LANE_W]),
            .mask     (rx_mask[k])
        );
    end

    if (OUT_REG != 0) begin : g_out_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_bus_dq  <= '0;
                tx_bus_dmi <= '0;
            end else begin
                tx_bus_dq  <= enc_dq;
                tx_bus_dmi <= enc_dmi;
            end
        end
    end else begin : g_out_comb
        assign tx_bus_dq  = enc_dq;
        assign tx_bus_dmi = enc_dmi;
    end
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk
    import dbi_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int OUT_REG = 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    inv_rd_en,
    input logic                    inv_wr_en,
    input logic                    tx_write,
    input logic [LANES*LANE_W-1:0] tx_data,
    input logic [LANES-1:0]        tx_mask,
    input logic [LANES*LANE_W-1:0] tx_bus_dq,
    input logic [LANES-1:0]        tx_bus_dmi,
    input logic                    rx_write,
    input logic [LANES*LANE_W-1:0] rx_bus_dq,
    input logic [LANES-1:0]        rx_bus_dmi,
    input logic [LANES*LANE_W-1:0] rx_data,
    input logic [LANES-1:0]        rx_mask
);
    // inputs aligned with the transmit bus they produced
    logic                    a_write, a_inv_rd, a_inv_wr;
    logic [LANES*LANE_W-1:0] a_data;
    logic [LANES-1:0]        a_mask;

    if (OUT_REG != 0) begin : g_align
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_write  <= 1'b0;
                a_inv_rd <= 1'b0;
                a_inv_wr <= 1'b0;
                a_data   <= '0;
                a_mask   <= '0;
            end else begin
                a_write  <= tx_write;
                a_inv_rd <= inv_rd_en;
                a_inv_wr <= inv_wr_en;
                a_data   <= tx_data;
                a_mask   <= tx_mask;
            end
        end
    end else begin : g_direct
        assign a_write  = tx_write;
        assign a_inv_rd = inv_rd_en;
        assign a_inv_wr = inv_wr_en;
        assign a_data   = tx_data;
        assign a_mask   = tx_mask;
    end

    logic a_inv_on;
    assign a_inv_on = a_write ? a_inv_wr : a_inv_rd;

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        // R3
        ones_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_inv_on && !(a_write && a_mask[k]))
                |-> (ones_of(tx_bus_dq[k*LANE_W +: LANE_W]) <= CNT_W'(LANE_W/2)));
        // R5
        mask_inv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_write && a_mask[k] && a_inv_wr)
                |-> (tx_bus_dq[k*LANE_W +: LANE_W] == '1 && !tx_bus_dmi[k]));
        // R4
        mask_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_write && a_mask[k] && !a_inv_wr)
                |-> (tx_bus_dmi[k] && tx_bus_dq[k*LANE_W +: LANE_W] == a_data[k*LANE_W +: LANE_W]));
        // R6
        passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_inv_on && !(a_write && a_mask[k]))
                |-> (!tx_bus_dmi[k] && tx_bus_dq[k*LANE_W +: LANE_W] == a_data[k*LANE_W +: LANE_W]));
    end

    // R9
    rd_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_write |-> (rx_mask == '0));
    // R10
    wr_plain_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_write && !inv_wr_en) |-> (rx_mask == rx_bus_dmi && rx_data == rx_bus_dq));
endmodule

bind dbi_codec dbi_codec_chk #(.LANES(LANES), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_rd_en (inv_rd_en),
    .inv_wr_en (inv_wr_en),
    .tx_write  (tx_write),
    .tx_data   (tx_data),
    .tx_mask   (tx_mask),
    .tx_bus_dq (tx_bus_dq),
    .tx_bus_dmi(tx_bus_dmi),
    .rx_write  (rx_write),
    .rx_bus_dq (rx_bus_dq),
    .rx_bus_dmi(rx_bus_dmi),
    .rx_data   (rx_data),
    .rx_mask   (rx_mask)
);

// File: tb/test_dbi_codec.sv
`timescale 1ns/1ps
module test_dbi_codec;
    localparam int LANES = 4;
    localparam int W     = LANES * 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic             inv_rd_en, inv_wr_en, tx_write, rx_write;
    logic [W-1:0]     tx_data, tx_bus_dq, rx_bus_dq, rx_data;
    logic [LANES-1:0] tx_mask, tx_bus_dmi, rx_bus_dmi, rx_mask;

    dbi_codec #(.LANES(LANES), .OUT_REG(1)) i_dbi_codec (
        .clk(clk), .rst_n(rst_n), .inv_rd_en(inv_rd_en), .inv_wr_en(inv_wr_en),
        .tx_write(tx_write), .tx_data(tx_data), .tx_mask(tx_mask),
        .tx_bus_dq(tx_bus_dq), .tx_bus_dmi(tx_bus_dmi),
        .rx_write(rx_write), .rx_bus_dq(rx_bus_dq), .rx_bus_dmi(rx_bus_dmi),
        .rx_data(rx_data), .rx_mask(rx_mask)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected transmit bus for the inputs driven in the previous cycle
    logic [W-1:0]     pend_dq  = '0;
    logic [LANES-1:0] pend_dmi = '0;
    logic [LANES-1:0] pend_lim = '0;
    string            pend_tag [LANES];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (b[i]) n++;
        return n;
    endfunction

    task automatic model_enc(input bit wr, input bit ri, input bit wi, input logic [7:0] d,
                             input bit m, output logic [7:0] q, output logic dmi,
                             output bit lim, output string tag);
        bit act_inv = wr ? wi : ri;
        lim = 0;
        if (wr && m && wi) begin
            q = 8'hFF; dmi = 1'b1 ^ 1'b1; tag = "R5";
        end else if (wr && m) begin
            q = d; dmi = 1'b1; tag = "R4";
        end else if (act_inv && ones(d) >= 5) begin
            q = ~d; dmi = 1'b1; tag = "R2"; lim = 1;
        end else begin
            q = d; dmi = 1'b0;
            lim = act_inv;
            tag = (!wr && m) ? "R7" : (act_inv ? "R2" : "R6");
        end
    endtask

    task automatic model_dec(input bit wr, input bit ri, input bit wi, input logic [7:0] q,
                             input logic dmi, output logic [7:0] d, output logic m,
                             output string tag);
        m = 1'b0; d = q;
        if (!wr) begin
            if (ri && dmi) d = ~q;
            tag = "R9";
        end else if (!wi) begin
            m = dmi; tag = "R10";
        end else begin
            tag = "R11";
            if (dmi) d = ~q;
            else if (ones(q) >= 5) m = 1'b1;
        end
    endtask

    task automatic step(input bit ri, input bit wi, input bit wr, input logic [W-1:0] d,
                        input logic [LANES-1:0] m, input bit rwr, input logic [W-1:0] rq,
                        input logic [LANES-1:0] rdmi);
        logic [7:0] eq, ed;
        logic       edmi, em;
        bit         lim;
        string      tag;
        @(negedge clk);
        for (int k = 0; k < LANES; k++) begin
            chk($sformatf("%s lane%0d dq (R8 R12)", pend_tag[k], k),
                32'(tx_bus_dq[k*8 +: 8]), 32'(pend_dq[k*8 +: 8]));
            chk($sformatf("%s lane%0d dmi (R8 R12)", pend_tag[k], k),
                32'(tx_bus_dmi[k]), 32'(pend_dmi[k]));
            if (pend_lim[k])
                chk($sformatf("R3 lane%0d at most 4 high", k),
                    32'(ones(tx_bus_dq[k*8 +: 8]) <= 4), 32'd1);
        end
        inv_rd_en = ri; inv_wr_en = wi; tx_write = wr; tx_data = d; tx_mask = m;
        rx_write = rwr; rx_bus_dq = rq; rx_bus_dmi = rdmi;
        #1;
        for (int k = 0; k < LANES; k++) begin
            model_dec(rwr, ri, wi, rq[k*8 +: 8], rdmi[k], ed, em, tag);
            chk($sformatf("%s lane%0d rx_data", tag, k), 32'(rx_data[k*8 +: 8]), 32'(ed));
            chk($sformatf("%s lane%0d rx_mask", tag, k), 32'(rx_mask[k]), 32'(em));
            model_enc(wr, ri, wi, d[k*8 +: 8], m[k], eq, edmi, lim, tag);
            pend_dq[k*8 +: 8] = eq;
            pend_dmi[k]       = edmi;
            pend_lim[k]       = lim;
            pend_tag[k]       = tag;
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < LANES; k++) pend_tag[k] = "R1";
        rst_n = 1'b0;
        inv_rd_en = 0; inv_wr_en = 0; tx_write = 0; rx_write = 0;
        tx_data = '0; tx_mask = '0; rx_bus_dq = '0; rx_bus_dmi = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset dq", 32'(tx_bus_dq), 32'd0);
        chk("R1 reset dmi", 32'(tx_bus_dmi), 32'd0);
        rst_n = 1'b1;

        // reads, read inversion on: 4 ones, 5 ones, all ones, zero per lane (R2 R12)
        step(1, 0, 0, 32'h000F_1F_FF ^ 32'h0, 4'b0000, 0, 32'hE0FF_0F00, 4'b1010);
        step(1, 0, 0, 32'h001F_FF0F, 4'b1111, 0, 32'h1F1F_1F1F, 4'b1111); // R7 mask ignored
        // reads, read inversion off
        step(0, 1, 0, 32'hFF1F_0F00, 4'b0101, 0, 32'hFF00_FF00, 4'b1111);
        // writes, write inversion on, masked lanes 0 and 2 (R5)
        step(0, 1, 1, 32'hF70F_3C_FE, 4'b0101, 1, 32'h1F0F_FFE0, 4'b0001);
        // write decode boundary: 4 ones not masked, 5 ones masked (R11)
        step(0, 1, 1, 32'h0000_0000, 4'b0000, 1, 32'h0F1F_F0F8, 4'b0000);
        // writes, write inversion off, masked lanes 1 and 3 (R4 R10)
        step(1, 0, 1, 32'hAB1F_FF01, 4'b1010, 1, 32'hFFFF_0000, 4'b0110);
        // no inversion anywhere (R6)
        step(0, 0, 1, 32'hFFFF_FFFF, 4'b0000, 0, 32'hFFFF_FFFF, 4'b1111);
        step(0, 0, 0, 32'hF0F1_F3F7, 4'b0000, 1, 32'h0000_00FF, 4'b0000);

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            step(1'($urandom), 1'($urandom), 1'($urandom), $urandom, 4'($urandom),
                 1'($urandom), $urandom, 4'($urandom));
        end
        // flush last transmit
        step(0, 0, 0, '0, '0, 0, '0, '0);

        finished = 1;
        summary();
        $finish;
    end
endmodule